// File: doc/BRIEF.md
# Windowed Integer Register File

This block is a 32-bit integer register file whose 32 visible registers are mapped onto a larger physical array through a circular window pointer. Registers r0 to r7 are globals that every window shares. The other 24 visible registers are the outs, locals and ins of the current window. Neighbouring windows overlap, so the outs of a caller become the ins of the callee once it has moved to a new window.

The block has two combinational read ports and one write port. A save request moves the window pointer down by one and a restore request moves it up by one, both modulo the window count. Before either request moves the pointer, it checks the target window against an invalid-window mask. If the target is marked, the block raises a spill indication for a save or a fill indication for a restore. It then leaves the pointer where it was and drops the register write of that cycle. A privileged port loads the mask. The trap handler and the memory traffic for spilling and filling sit outside the block.

Top module: `win_regfile`

## Requirements
- R1: Reading visible address 0 on either read port always returns 0. A write to address 0 is discarded and changes no register.
- R2: Addresses 1 to 7 reach the same registers in every window. Addresses 16 to 23 (locals) are private to the window. Addresses 8 to 15 (outs) of window w are the same registers as addresses 24 to 31 (ins) of window w-1 mod NWIN. Equivalently, the ins of window w are the outs of window w+1 mod NWIN.
- R3: When save_i is high, the window pointer cwp_o becomes cwp-1 mod NWIN on the next edge. When restore_i is high without save_i, it becomes cwp+1 mod NWIN. When both are high, only the save is performed. In every case this holds only if no trap is raised.
- R4: spill_o is high in the same cycle as a save whose target window has its bit set in wim_o. fill_o is high in the same cycle as a restore, with save_i low, whose target window has its bit set in wim_o. Both indications are low when there is no request.
- R5: In a cycle that raises a spill or fill indication, cwp_o keeps its value and the register write of that cycle is suppressed.
- R6: In a cycle with a save or restore that moves the pointer, the read ports decode their addresses in the old window. The write port decodes its address in the new window.
- R7: When the write and a read reach the same physical register in the same cycle, the read returns the data being written.
- R8: A write through the mask port sets wim_o to wim_wr_data_i at the next edge. The trap checks of later cycles use the new mask, while a request in the same cycle still uses the old mask.
- R9: After reset, cwp_o is NWIN-1 and wim_o has only bit 0 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rs1_addr_i | input | 5 | Visible address, read port 1 |
| rs1_data_o | output | 32 | Read data, port 1 |
| rs2_addr_i | input | 5 | Visible address, read port 2 |
| rs2_data_o | output | 32 | Read data, port 2 |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 5 | Visible write address |
| wr_data_i | input | 32 | Write data |
| save_i | input | 1 | Move the window pointer down |
| restore_i | input | 1 | Move the window pointer up |
| wim_wr_en_i | input | 1 | Privileged invalid-mask write enable |
| wim_wr_data_i | input | NWIN | New invalid-window mask |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| wim_o | output | NWIN | Current invalid-window mask |
| spill_o | output | 1 | Save blocked by invalid window |
| fill_o | output | 1 | Restore blocked by invalid window |

## Verification
The bench builds the block with NWIN=4. A window count this small lets short random runs wrap the pointer both ways many times. Pointers 0 and NWIN-1 then occur often, and so does the overlap between window NWIN-1 and window 0. With random mask writes, both trap kinds fire frequently, and so do same-cycle collisions between a write in the new window and a read in the old one.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int LREG_W = 5;
  localparam int BANK   = 8;

  typedef logic [LREG_W-1:0] lreg_t;

  function automatic int phys_depth(int nwin);
    return BANK + 2 * BANK * nwin;
  endfunction
endpackage

// File: rtl/wrf_win_ctrl.sv
module wrf_win_ctrl #(
  parameter int NWIN  = 8,
  localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             wim_we_i,
  input  logic [NWIN-1:0]  wim_d_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [CWP_W-1:0] next_win_o,
  output logic [NWIN-1:0]  wim_o,
  output logic             spill_o,
  output logic             fill_o
);
  localparam logic [CWP_W-1:0] CWP_TOP = CWP_W'(NWIN - 1);
  localparam logic [NWIN-1:0]  WIM_RST = NWIN'(1);

  logic [CWP_W-1:0] cwp_q, cwp_dn, cwp_up;
  logic [NWIN-1:0]  wim_q;
  logic             do_save, do_rest, move;

  assign cwp_dn  = (cwp_q == '0) ? CWP_TOP : cwp_q - 1'b1;
  assign cwp_up  = (cwp_q == CWP_TOP) ? '0 : cwp_q + 1'b1;
  assign do_save = save_i;
  assign do_rest = restore_i & ~save_i;   // save wins when both requested
  assign spill_o = do_save & wim_q[cwp_dn];
  assign fill_o  = do_rest & wim_q[cwp_up];
  assign move    = (do_save & ~spill_o) | (do_rest & ~fill_o);

  always_comb begin
    next_win_o = cwp_q;
    if (move) next_win_o = do_save ? cwp_dn : cwp_up;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cwp_q <= CWP_TOP;
      wim_q <= WIM_RST;
    end else begin
      cwp_q <= next_win_o;
      if (wim_we_i) wim_q <= wim_d_i;
    end
  end

  assign cwp_o = cwp_q;
  assign wim_o = wim_q;

  a_r3_save_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_i && !spill_o) |=> (cwp_q == (($past(cwp_q) == '0) ? CWP_TOP : $past(cwp_q) - 1'b1)));
  a_r3_restore_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restore_i && !save_i && !fill_o) |=> (cwp_q == (($past(cwp_q) == CWP_TOP) ? '0 : $past(cwp_q) + 1'b1)));
  a_r4_trap_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(spill_o && fill_o));
  a_r5_trap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o || fill_o) |=> $stable(cwp_q));
endmodule

// File: rtl/wrf_addr_map.sv
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter int NWIN  = 8,
  localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int DEPTH = phys_depth(NWIN),
  localparam int PA_W  = $clog2(DEPTH)
) (
  input  logic [CWP_W-1:0] win_i,
  input  lreg_t            lreg_i,
  output logic [PA_W-1:0]  preg_o
);
  int base, base_nx, p;

  always_comb begin
    base    = BANK + 2 * BANK * int'(win_i);
    base_nx = (win_i == CWP_W'(NWIN - 1)) ? BANK : base + 2 * BANK;
    unique case (lreg_i[4:3])
      2'd0:    p = int'(lreg_i);
      2'd1:    p = base + int'(lreg_i[2:0]);
      2'd2:    p = base + BANK + int'(lreg_i[2:0]);
      default: p = base_nx + int'(lreg_i[2:0]);  // ins alias outs of next window
    endcase
    preg_o = PA_W'(p);
  end
endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
  parameter int DW    = 32,
  parameter int DEPTH = 136,
  parameter int NRD   = 2,
  localparam int PA_W = $clog2(DEPTH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [PA_W-1:0]           waddr_i,
  input  logic [DW-1:0]             wdata_i,
  input  logic [NRD-1:0][PA_W-1:0]  raddr_i,
  output logic [NRD-1:0][DW-1:0]    rdata_o
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = (we_i && waddr_i == raddr_i[g]) ? wdata_i : mem[raddr_i[g]];
  end

  a_r1_no_zero_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (waddr_i != '0));
endmodule

// File: rtl/win_regfile.sv
module win_regfile
  import wrf_pkg::*;
#(
  parameter int NWIN  = 8,
  parameter int DW    = 32,
  localparam int CWP_W = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int DEPTH = phys_depth(NWIN),
  localparam int PA_W  = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [4:0]       rs1_addr_i,
  output logic [DW-1:0]    rs1_data_o,
  input  logic [4:0]       rs2_addr_i,
  output logic [DW-1:0]    rs2_data_o,
  input  logic             wr_en_i,
  input  logic [4:0]       wr_addr_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             save_i,
  input  logic             restore_i,
  input  logic             wim_wr_en_i,
  input  logic [NWIN-1:0]  wim_wr_data_i,
  output logic [CWP_W-1:0] cwp_o,
  output logic [NWIN-1:0]  wim_o,
  output logic             spill_o,
  output logic             fill_o
);
  logic [CWP_W-1:0]         cwp, next_win;
  logic [1:0][PA_W-1:0]     rd_pa;
  logic [PA_W-1:0]          wr_pa;
  logic [1:0][DW-1:0]       rd_raw;
  logic [1:0][4:0]          rd_la;
  logic                     arr_we;

  assign rd_la[0] = rs1_addr_i;
  assign rd_la[1] = rs2_addr_i;

  wrf_win_ctrl #(.NWIN(NWIN)) u_ctrl (
    .clk_i, .rst_ni, .save_i, .restore_i,
    .wim_we_i(wim_wr_en_i), .wim_d_i(wim_wr_data_i),
    .cwp_o(cwp), .next_win_o(next_win), .wim_o,
    .spill_o, .fill_o
  );

  for (genvar g = 0; g < 2; g++) begin : g_rmap
    wrf_addr_map #(.NWIN(NWIN)) u_map (
      .win_i(cwp), .lreg_i(rd_la[g]), .preg_o(rd_pa[g])
    );
  end

  wrf_addr_map #(.NWIN(NWIN)) u_wmap (
    .win_i(next_win), .lreg_i(wr_addr_i), .preg_o(wr_pa)
  );

  assign arr_we = wr_en_i && (wr_addr_i != '0) && !spill_o && !fill_o;

  wrf_array #(.DW(DW), .DEPTH(DEPTH), .NRD(2)) u_array (
    .clk_i, .rst_ni, .we_i(arr_we), .waddr_i(wr_pa), .wdata_i(wr_data_i),
    .raddr_i(rd_pa), .rdata_o(rd_raw)
  );

  assign rs1_data_o = (rs1_addr_i == '0) ? '0 : rd_raw[0];
  assign rs2_data_o = (rs2_addr_i == '0) ? '0 : rd_raw[1];
  assign cwp_o      = cwp;

  a_r5_trap_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spill_o || fill_o) |-> !arr_we);
  a_r4_idle_no_trap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_i && !restore_i) |-> (!spill_o && !fill_o));
endmodule

// File: tb/win_regfile_bench.sv
`timescale 1ns/1ps
module win_regfile_bench;
  localparam int N     = 4;
  localparam int DEPTH = 8 + 16 * N;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [4:0]   rs1_a, rs2_a, wa;
  logic [31:0]  rs1_d, rs2_d, wd;
  logic         we, sv, rs, wimwe, spill, fill;
  logic [N-1:0] wimd, wim;
  logic [1:0]   cwp;

  win_regfile #(.NWIN(N)) u_win_regfile (
    .clk_i(clk), .rst_ni(rst_n),
    .rs1_addr_i(rs1_a), .rs1_data_o(rs1_d),
    .rs2_addr_i(rs2_a), .rs2_data_o(rs2_d),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd),
    .save_i(sv), .restore_i(rs),
    .wim_wr_en_i(wimwe), .wim_wr_data_i(wimd),
    .cwp_o(cwp), .wim_o(wim), .spill_o(spill), .fill_o(fill)
  );

  int checks = 0, bad = 0;
  int m_cwp, m_wim;
  logic [31:0] m_mem [DEPTH];
  bit          m_val [DEPTH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // physical slot per R2: globals shared, ins of w = outs of w+1
  function automatic int phys(int w, int l);
    int b = 8 + 16 * w;
    int bn = 8 + 16 * ((w + 1) % N);
    case (l / 8)
      0: return l;
      1: return b + l % 8;
      2: return b + 8 + l % 8;
      default: return bn + l % 8;
    endcase
  endfunction

  function automatic int dn(int w); return (w + N - 1) % N; endfunction
  function automatic int up(int w); return (w + 1) % N; endfunction

  task automatic step(bit s, bit r, bit e, int a, logic [31:0] d,
                      int a1, int a2, bit me, int md);
    bit es, ef, mv, wok;
    int nw, pw;
    int ra [2];
    logic [31:0] rv [2];
    chk("R3 cwp", 32'(cwp), 32'(m_cwp));
    chk("R8 wim", 32'(wim), 32'(m_wim));
    sv = s; rs = r; we = e; wa = 5'(a); wd = d;
    rs1_a = 5'(a1); rs2_a = 5'(a2); wimwe = me; wimd = N'(md);
    #1;
    es  = s && m_wim[dn(m_cwp)];
    ef  = r && !s && m_wim[up(m_cwp)];
    mv  = (s && !es) || (r && !s && !ef);
    nw  = mv ? (s ? dn(m_cwp) : up(m_cwp)) : m_cwp;
    wok = e && a != 0 && !es && !ef;
    pw  = phys(nw, a);
    chk("R4 spill", 32'(spill), 32'(es));
    chk("R4 fill", 32'(fill), 32'(ef));
    ra[0] = a1; ra[1] = a2; rv[0] = rs1_d; rv[1] = rs2_d;
    for (int k = 0; k < 2; k++) begin
      int p = phys(m_cwp, ra[k]);
      if (ra[k] == 0) chk("R1 zero", rv[k], 32'd0);
      else if (wok && pw == p) chk("R7 bypass", rv[k], d);
      else if (m_val[p]) chk(mv ? "R6 old window read" : "R2 read", rv[k], m_mem[p]);
    end
    @(posedge clk);
    if (wok) begin m_mem[pw] = d; m_val[pw] = 1; end
    m_cwp = nw;
    if (me) m_wim = md;
    @(negedge clk);
  endtask

  task automatic idle_rd(int a1, int a2);
    step(0, 0, 0, 0, 0, a1, a2, 0, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7341));
    for (int i = 0; i < DEPTH; i++) m_val[i] = 0;
    m_cwp = N - 1; m_wim = 1;
    sv = 0; rs = 0; we = 0; wa = 0; wd = 0; rs1_a = 0; rs2_a = 0; wimwe = 0; wimd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R9 reset state
    chk("R9 reset cwp", 32'(cwp), 32'(N - 1));
    chk("R9 reset wim", 32'(wim), 32'd1);
    // R1 write to r0 is dropped
    step(0, 0, 1, 0, 32'hFFFF_FFFF, 0, 0, 0, 0);
    idle_rd(0, 0);
    // R2 setup in window 3
    step(0, 0, 1, 1, 32'h11, 0, 0, 0, 0);
    step(0, 0, 1, 8, 32'hA8, 0, 0, 0, 0);
    step(0, 0, 1, 16, 32'hB0, 0, 0, 0, 0);
    // R7 same-cycle write/read
    step(0, 0, 1, 9, 32'h99, 9, 9, 0, 0);
    // R6 save: read r8 old, write r16 in new window 2
    step(1, 0, 1, 16, 32'hC0, 8, 16, 0, 0);
    chk("R3 save to 2", 32'(cwp), 32'd2);
    idle_rd(24, 1);   // R2 ins alias caller's outs, global shared
    chk("R2 ins alias outs", rs1_d, 32'hA8);
    chk("R2 global shared", rs2_d, 32'h11);
    step(0, 1, 0, 0, 0, 16, 0, 0, 0);
    idle_rd(16, 0);
    chk("R2 local private", rs1_d, 32'hB0);
    // R5 restore into invalid window 0 traps, write dropped
    step(0, 1, 1, 16, 32'hDEAD, 0, 0, 0, 0);
    chk("R5 cwp held", 32'(cwp), 32'd3);
    idle_rd(16, 0);
    chk("R5 write suppressed", rs1_d, 32'hB0);
    // save down to spill
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 1, 17, 32'h55, 0, 0, 0, 0);
    chk("R4 spill hold", 32'(cwp), 32'd1);
    // R8 clear mask; same-cycle save still uses old mask
    step(1, 0, 0, 0, 0, 0, 0, 1, 0);
    chk("R8 old mask used", 32'(cwp), 32'd1);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R8 new mask used", 32'(cwp), 32'd0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 save wraps", 32'(cwp), 32'(N - 1));
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 restore wraps", 32'(cwp), 32'd0);
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R3 save priority", 32'(cwp), 32'(N - 1));
    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int rnd = int'($urandom_range(99));
      bit s = rnd < 15;
      bit r = rnd >= 15 && rnd < 32 || rnd == 99;
      bit me = $urandom_range(99) < 4;
      step(s, r, $urandom_range(1) == 1, int'($urandom_range(31)), $urandom,
           int'($urandom_range(31)), int'($urandom_range(31)),
           me, int'($urandom_range(2**N - 1)));
    end
    idle_rd(0, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule